// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It waits for a program or erase to finish by reading the device status over and over. The host issues the command sequence first. Once the final write pulse of that sequence is over (the fourth for a program, the sixth for an erase), the host pulses `start`. The poller then reads status words back to back over a simple strobe/acknowledge bus. After each pair of reads it compares the toggle bit, bit 6.

While the device is busy, bit 6 flips on every read. When two consecutive reads agree, the operation has finished. Bit 5 flags a timing-limit failure, but it can also read 1 after a good completion. For that reason the poller takes a second pair of reads before it decides. If the toggle bit is still flipping in that pair, the poller writes the reset command so the device returns to array reading, and then reports failure. A poll budget forces the same failure path when the toggle never stops.

There is an optional fast path for the ready/busy pins. These are open-drain lines from one or more devices, so they combine as a wired-AND. When the fast path is enabled and every pin reads high, the poller reports completion without waiting for the toggle to settle.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy`, `done`, `fail`, `bus_rd` and `bus_wr` are all low.
- R2: No transfer is requested while `busy` is low. `bus_rd` and `bus_wr` are never high together. A request stays high until a cycle in which `bus_ack` is high, and each such cycle completes exactly one transfer.
- R3: After a pair of back-to-back reads whose bit 6 values are equal, the poller reports completion. It performs no further bus transfers and writes no command.
- R4: When the two reads of a pair differ in bit 6 and either read has bit 5 set, exactly two more reads follow. Equal bit 6 in those two reads gives completion. Different bit 6 gives failure.
- R5: A failure issues exactly one write transfer of data 0xF0 on `bus_wdata` (bits 7:0). `fail` rises in the cycle after that write is acknowledged.
- R6: After MAX_POLLS consecutive pairs that toggle with bit 5 clear, the poller takes the R5 failure path. That run contains exactly 2*MAX_POLLS reads.
- R7: `done` and `fail` are one-cycle pulses and are never high together. `busy` is high from the cycle after an accepted start through the pulse cycle, and low in the cycle after the pulse.
- R8: A `start` pulse while `busy` is high is ignored. The run ends with the same transfers and outcome it would have had without that pulse.
- R9: With `rb_en` high, the ready pins are ANDed together, and high means ready. If all pins are high when `start` arrives, `done` pulses with no bus transfer. If any pin is low, polling proceeds as in R3 to R6.
- R10: With `rb_en` low, the ready pins have no effect on transfers or outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| rb_en | input | 1 | Enable the ready/busy fast path |
| rdy_pins | input | NDEV | Ready/busy levels of the devices, high = ready |
| bus_rd | output | 1 | Status read request |
| bus_wr | output | 1 | Command write request |
| bus_wdata | output | DQ_W | Write data (reset command) |
| bus_ack | input | 1 | Transfer completes in this cycle |
| bus_rdata | input | DQ_W | Read data, valid with `bus_ack` |
| busy | output | 1 | Poll run in progress |
| done | output | 1 | Completion pulse |
| fail | output | 1 | Failure pulse |

## Verification
On every cycle the assertions check the bus rules and the outcome pulses:
- read and write requests never overlap;
- the bus is quiet while idle;
- a request is held until it is acknowledged;
- the write carries the reset command;
- `fail` is always preceded by an acknowledged write;
- the pulses are single and exclusive;
- the poll counter stays within its budget.

Some behaviour can only be shown by the bench's scenarios, which run against a model device. These are the number of reads taken before a decision, the choice between completion and failure after a bit-5 recheck, the watchdog's read count, and a start pulse that is ignored mid-run. The same holds for the wired-AND fast path and for the pins having no effect when the fast path is disabled.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_A,
    S_RD_B,
    S_EVAL,
    S_RECHK_A,
    S_RECHK_B,
    S_RST_WR,
    S_DONE,
    S_FAIL
  } tbp_state_e;

  // bit positions decoded from each status word
  localparam int TGL_BIT = 6;
  localparam int ERR_BIT = 5;

  // command that returns the device to array reading
  localparam logic [7:0] RESET_CMD = 8'hF0;

  function automatic logic is_read_state(tbp_state_e s);
    return (s == S_RD_A) || (s == S_RD_B) || (s == S_RECHK_A) || (s == S_RECHK_B);
  endfunction

endpackage

// File: rtl/tbp_rdy_sync.sv
module tbp_rdy_sync #(
  parameter int NDEV   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDEV-1:0] pins,
  output logic            rdy_s
);

  // open-drain lines: the shared level is high only if every device is ready
  logic all_rdy;
  assign all_rdy = &pins;

  generate
    if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= all_rdy;
      end
      assign rdy_s = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= {q[STAGES-2:0], all_rdy};
      end
      assign rdy_s = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tbp_sample.sv
module tbp_sample
  import tbp_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_a,
  input  logic            cap_b,
  input  logic [DQ_W-1:0] rdata,
  output logic            pair_tgl,
  output logic            pair_err,
  output logic            live_tgl
);

  logic [DQ_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      pair_tgl <= 1'b0;
      pair_err <= 1'b0;
    end else begin
      if (cap_a) first_q <= rdata;
      if (cap_b) begin
        pair_tgl <= first_q[TGL_BIT] ^ rdata[TGL_BIT];
        pair_err <= first_q[ERR_BIT] | rdata[ERR_BIT];
      end
    end
  end

  // toggle between the held first read and the read now on the bus
  assign live_tgl = first_q[TGL_BIT] ^ rdata[TGL_BIT];

endmodule

// File: rtl/tbp_wdog.sv
module tbp_wdog #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic expired
);

  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(MAX_POLLS - 1));

  // R6
  wd_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAX_POLLS));

endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl
  import tbp_pkg::*;
#(
  parameter int DQ_W        = 8,
  parameter int NDEV        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_POLLS   = 4096
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            rb_en,
  input  logic [NDEV-1:0] rdy_pins,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [DQ_W-1:0] bus_wdata,
  input  logic            bus_ack,
  input  logic [DQ_W-1:0] bus_rdata,
  output logic            busy,
  output logic            done,
  output logic            fail
);

  tbp_state_e state, nxt;
  logic rdy_s, fast_ok;
  logic pair_tgl, pair_err, live_tgl, wd_exp;
  logic cap_a, cap_b, wd_inc, wd_clr;

  tbp_rdy_sync #(.NDEV(NDEV), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins(rdy_pins), .rdy_s(rdy_s)
  );

  assign cap_a = bus_ack && ((state == S_RD_A) || (state == S_RECHK_A));
  assign cap_b = bus_ack && (state == S_RD_B);

  tbp_sample #(.DQ_W(DQ_W)) u_sample (
    .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b), .rdata(bus_rdata),
    .pair_tgl(pair_tgl), .pair_err(pair_err), .live_tgl(live_tgl)
  );

  assign wd_clr = (state == S_IDLE);
  assign wd_inc = (state == S_EVAL) && (nxt == S_RD_A);

  tbp_wdog #(.MAX_POLLS(MAX_POLLS)) u_wdog (
    .clk(clk), .rst(rst), .clr(wd_clr), .inc(wd_inc), .expired(wd_exp)
  );

  assign fast_ok = rb_en && rdy_s;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (start) nxt = fast_ok ? S_DONE : S_RD_A;
      S_RD_A:    if (bus_ack) nxt = S_RD_B;
      S_RD_B:    if (bus_ack) nxt = S_EVAL;
      S_EVAL: begin
        if (!pair_tgl || fast_ok) nxt = S_DONE;
        else if (pair_err)        nxt = S_RECHK_A;
        else if (wd_exp)          nxt = S_RST_WR;
        else                      nxt = S_RD_A;
      end
      S_RECHK_A: if (bus_ack) nxt = S_RECHK_B;
      S_RECHK_B: if (bus_ack) nxt = live_tgl ? S_RST_WR : S_DONE;
      S_RST_WR:  if (bus_ack) nxt = S_FAIL;
      S_DONE:    nxt = S_IDLE;
      S_FAIL:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  // outputs registered from the next-state decode
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      bus_rd <= 1'b0;
      bus_wr <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      state  <= nxt;
      bus_rd <= is_read_state(nxt);
      bus_wr <= (nxt == S_RST_WR);
      busy   <= (nxt != S_IDLE);
      done   <= (nxt == S_DONE);
      fail   <= (nxt == S_FAIL);
    end
  end

  assign bus_wdata = DQ_W'(RESET_CMD);

  // R7
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  fail_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);
  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_rd && !bus_wr));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_ack) |=> bus_rd);
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ack) |=> bus_wr);
  // R5
  fail_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(bus_wr && bus_ack));
  // R5
  wr_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_wdata[7:0] == RESET_CMD));

endmodule

// File: tb/tb_tbp_poll_ctrl.sv
module tb_tbp_poll_ctrl;

  localparam int DQ_W = 8;
  localparam int NDEV = 2;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rb_en = 1'b0;
  logic [NDEV-1:0] rdy_pins = '0;
  logic bus_rd, bus_wr, busy, done, fail;
  logic [DQ_W-1:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [DQ_W-1:0] bus_rdata = '0;

  always #2 clk = ~clk;

  tbp_poll_ctrl #(.DQ_W(DQ_W), .NDEV(NDEV), .SYNC_STAGES(2), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst(rst), .start(start), .rb_en(rb_en), .rdy_pins(rdy_pins),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .fail(fail)
  );

  int checks = 0;
  int fails  = 0;

  // model device state
  int m_busy  = 0;
  int m_dq5   = 1000;
  logic [7:0] m_final = 8'h00;
  int n_rd = 0;
  int n_wr = 0;
  logic [7:0] last_wd = 8'h00;

  function automatic logic [7:0] st(int r);
    logic [7:0] v;
    if (r >= m_busy) return m_final;
    v = 8'(r * 91) & 8'h9F;
    v[6] = r[0];
    v[5] = (r >= m_dq5);
    return v;
  endfunction

  // expected outcome from the requirements
  task automatic predict(input bit fast, output int reads, output bit isfail);
    logic [7:0] a, b, c, d;
    int r, pairs;
    r = 0; pairs = 0; isfail = 1'b0; reads = 0;
    if (fast) return;
    forever begin
      a = st(r); b = st(r + 1); r += 2;
      if (a[6] == b[6]) break;
      if (a[5] || b[5]) begin
        c = st(r); d = st(r + 1); r += 2;
        isfail = (c[6] != d[6]);
        break;
      end
      pairs++;
      if (pairs == MAXP) begin isfail = 1'b1; break; end
    end
    reads = r;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model: answers at the falling edge, transfer completes at the next rising edge
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      bus_ack = 1'b0;
      if (bus_rd || bus_wr) begin
        if (lat == 0) begin
          bus_ack = 1'b1;
          if (bus_rd) begin bus_rdata = st(n_rd); n_rd++; end
          else begin last_wd = bus_wdata[7:0]; n_wr++; end
          lat = $urandom_range(0, 2);
        end else lat--;
      end
    end
  end

  task automatic run_case(input string tag, input int bsy, input int dq5, input logic [7:0] fin,
                          input bit rbe, input logic [NDEV-1:0] pins, input bit restart);
    int exp_rd, rd_after;
    bit exp_fail, got;
    m_busy = bsy; m_dq5 = dq5; m_final = fin;
    n_rd = 0; n_wr = 0; last_wd = 8'h00;
    rb_en = rbe; rdy_pins = pins;
    repeat (4) @(negedge clk);
    predict(rbe && (&pins), exp_rd, exp_fail);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done || fail) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, {tag, " outcome pulse seen"}, got, 1);
    chk(fail == exp_fail, {tag, " fail"}, fail, exp_fail);
    chk(done == !exp_fail, {tag, " done"}, done, !exp_fail);
    chk(busy == 1'b1, "R7 busy in pulse cycle", busy, 1);
    chk(n_rd == exp_rd, {tag, " read count"}, n_rd, exp_rd);
    chk(n_wr == int'(exp_fail), "R5 write count", n_wr, int'(exp_fail));
    if (exp_fail) chk(last_wd == 8'hF0, "R5 reset command", last_wd, 8'hF0);
    @(negedge clk);
    chk(!done && !fail && !busy, "R7 pulse ends and busy drops", {done, fail, busy}, 0);
    rd_after = n_rd;
    repeat (8) @(negedge clk);
    chk(n_rd == rd_after && !bus_rd && !bus_wr, "R2 quiet after run", n_rd, rd_after);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !fail && !bus_rd && !bus_wr, "R1 reset outputs", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && !bus_rd && !bus_wr, "R1 after reset", busy, 0);
    // R2 no reads without a start
    repeat (5) @(negedge clk);
    chk(n_rd == 0 && n_wr == 0, "R2 no transfer before start", n_rd, 0);

    run_case("R3 already finished", 0, 1000, 8'h3C, 1'b0, 2'b00, 1'b0);
    run_case("R3 toggles then settles", 9, 1000, 8'h40, 1'b0, 2'b00, 1'b0);
    run_case("R4 recheck still toggling", 100, 3, 8'h00, 1'b0, 2'b00, 1'b0);
    run_case("R4 recheck settled", 2, 1, 8'h55, 1'b0, 2'b00, 1'b0);
    run_case("R6 watchdog", 1000, 1000, 8'h00, 1'b0, 2'b00, 1'b0);
    run_case("R8 start while busy", 9, 1000, 8'h40, 1'b0, 2'b00, 1'b1);
    run_case("R9 fast path ready", 40, 1000, 8'h00, 1'b1, 2'b11, 1'b0);
    run_case("R9 one pin busy", 9, 1000, 8'h40, 1'b1, 2'b01, 1'b0);
    run_case("R10 pins ignored", 9, 1000, 8'h40, 1'b0, 2'b11, 1'b0);

    for (int k = 0; k < 24; k++) begin
      int bsy, dq5;
      logic [7:0] fin;
      logic [NDEV-1:0] pins;
      bit rbe;
      bsy  = $urandom_range(0, 24);
      dq5  = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 24) : 1000;
      fin  = 8'($urandom);
      rbe  = 1'($urandom_range(0, 1));
      pins = NDEV'($urandom);
      run_case("R3 R4 R6 R9 random", bsy, dq5, fin, rbe, pins, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule